// File: doc/BRIEF.md
# Host-to-Device Virtual Wire Group Receiver

This block keeps the state of four host-driven virtual wires that share one programmable 8-bit host index. An already-decoded bus front end delivers update events (a valid strobe, an index and four new wire values). An event changes the wires only when its index equals the programmed index. Every wire has its own interrupt sensitivity: low level, high level, rising edge, falling edge, either edge, or off. The block drives a per-wire interrupt status vector, a combined interrupt line and a one-cycle wake pulse that only edge events can raise.

Firmware uses a byte-wide register port to program the index, the sensitivity of each wire, a reset-domain choice and a 4-bit reset pattern. The same port can read or overwrite single wire states. When the chosen reset domain is asserted, the four wires are held at the programmed pattern.

Top module: `hvw_rx`

## Requirements
- R1: After the block reset `rst`, all wires are 0, the interrupt status and `irq_o` are 0, the index byte reads 0x00 and every select byte reads 0x04 (off).
- R2: An update with `upd_valid_i` high and `upd_index_i` equal to the index byte loads `upd_value_i` bit n into wire n, and `wire_o` shows it one cycle later. An update whose index does not match leaves the wires unchanged.
- R3: Register port byte addresses are: 0 index; 1 reset config, with the pattern in bits 3:0 and the domain in bits 5:4; 2 interrupt status, where writing 1 clears a bit; 4+n select code of wire n in bits 3:0; 8+n state of wire n in bit 0. Read data appears one cycle after the address. A write changes only its own byte.
- R4: Select code 0x0 makes status bit n equal to 1 while wire n is 0. Select code 0x1 makes it equal to 1 while wire n is 1. A write-1-clear does not change a level-mode status bit.
- R5: Select codes 0xD (falling), 0xE (rising) and 0xF (both) set a sticky status bit when a matching edge occurs. A write-1-clear clears the bit, but an edge in the same cycle as the clear wins.
- R6: Select code 0x4 and every undefined code keep the status bit at 0.
- R7: An update that writes a wire's current value produces no edge event.
- R8: The reset config domain field picks one bit of `rst_dom_i` (0 link, 1 system, 2 super-IO, 3 platform). While that bit is high, the wires take the reset pattern, with bit n going to wire n. This takes priority over updates and firmware writes. The other `rst_dom_i` bits have no effect.
- R9: `irq_o` is the OR of the interrupt status bits in every cycle.
- R10: `wake_o` pulses for one cycle when a wire has a qualifying edge in an edge mode. It never pulses for level, off or undefined modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| rst_dom_i | input | 4 | Synchronous reset-domain requests, bit k is domain k |
| upd_valid_i | input | 1 | Wire update event strobe |
| upd_index_i | input | 8 | Host index carried by the update |
| upd_value_i | input | 4 | New wire values, bit n for wire n |
| reg_we_i | input | 1 | Register byte write enable |
| reg_addr_i | input | 4 | Register byte address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Registered read data |
| wire_o | output | 4 | Current wire states |
| irq_status_o | output | 4 | Per-wire interrupt status |
| irq_o | output | 1 | Combined interrupt |
| wake_o | output | 1 | One-cycle edge wake pulse |

## Verification
The bench builds the block with its default parameters: four wires, an 8-bit index, four reset domains and 8-bit register bytes. With these values all six defined select codes fit one group, and a table run can mix level and edge wires. The register map is the full 12-byte layout, so byte-isolation and readback of each select and state byte can be exercised. Four domain inputs make it possible to show that a non-selected domain does nothing.

// File: rtl/hvw_pkg.sv
package hvw_pkg;

  localparam logic [3:0] SEL_LOW  = 4'h0;
  localparam logic [3:0] SEL_HIGH = 4'h1;
  localparam logic [3:0] SEL_OFF  = 4'h4;
  localparam logic [3:0] SEL_FALL = 4'hD;
  localparam logic [3:0] SEL_RISE = 4'hE;
  localparam logic [3:0] SEL_BOTH = 4'hF;

  localparam int unsigned OFS_INDEX = 0;
  localparam int unsigned OFS_RCFG  = 1;
  localparam int unsigned OFS_STAT  = 2;
  localparam int unsigned OFS_SEL   = 4;
  localparam int unsigned OFS_STATE = 8;
  localparam int unsigned RCFG_DOM_LSB = 4;

  typedef struct packed {
    logic lvl_en;
    logic lvl_pol;
    logic rise_en;
    logic fall_en;
  } sens_t;

  function automatic sens_t decode_sel(input logic [3:0] code);
    sens_t s;
    s = '0;
    case (code)
      SEL_LOW:  s.lvl_en = 1'b1;
      SEL_HIGH: begin s.lvl_en = 1'b1; s.lvl_pol = 1'b1; end
      SEL_FALL: s.fall_en = 1'b1;
      SEL_RISE: s.rise_en = 1'b1;
      SEL_BOTH: begin s.rise_en = 1'b1; s.fall_en = 1'b1; end
      default:  s = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/hvw_cfg.sv
module hvw_cfg #(
  parameter int unsigned NWIRE  = 4,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DOM_W  = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wdata,
  output logic [IDX_W-1:0]            idx_q,
  output logic [NWIRE-1:0]            pat_q,
  output logic [DOM_W-1:0]            src_q,
  output logic [NWIRE-1:0][3:0]       sel_q
);
  import hvw_pkg::*;

  localparam logic [ADDR_W-1:0] A_IDX  = ADDR_W'(OFS_INDEX);
  localparam logic [ADDR_W-1:0] A_RCFG = ADDR_W'(OFS_RCFG);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      pat_q <= '0;
      src_q <= '0;
    end else if (we) begin
      if (addr == A_IDX) idx_q <= wdata[IDX_W-1:0];
      if (addr == A_RCFG) begin
        pat_q <= wdata[NWIRE-1:0];
        src_q <= wdata[RCFG_DOM_LSB +: DOM_W];
      end
    end
  end

  for (genvar g = 0; g < NWIRE; g++) begin : g_sel
    always_ff @(posedge clk) begin
      if (rst) sel_q[g] <= SEL_OFF;
      else if (we && addr == ADDR_W'(OFS_SEL + g)) sel_q[g] <= wdata[3:0];
    end
  end

endmodule

// File: rtl/hvw_wire.sv
module hvw_wire (
  input  logic       clk,
  input  logic       rst,
  input  logic       dom_act,
  input  logic       dom_val,
  input  logic       upd_hit,
  input  logic       upd_val,
  input  logic       fw_we,
  input  logic       fw_val,
  input  logic       clr,
  input  logic [3:0] sel,
  output logic       state_q,
  output logic       stat_q,
  output logic       stat_nxt,
  output logic       hit
);
  import hvw_pkg::*;

  logic  nxt, rose, fell;
  sens_t s;

  always_comb begin
    if (dom_act)      nxt = dom_val;
    else if (upd_hit) nxt = upd_val;
    else if (fw_we)   nxt = fw_val;
    else              nxt = state_q;
    rose = nxt & ~state_q;
    fell = ~nxt & state_q;
    s    = decode_sel(sel);
    hit  = (s.rise_en & rose) | (s.fall_en & fell);
    if (s.lvl_en)                  stat_nxt = (nxt == s.lvl_pol);
    else if (s.rise_en | s.fall_en) stat_nxt = hit | (stat_q & ~clr);
    else                           stat_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= 1'b0;
      stat_q  <= 1'b0;
    end else begin
      state_q <= nxt;
      stat_q  <= stat_nxt;
    end
  end

endmodule

// File: rtl/hvw_rx.sv
module hvw_rx #(
  parameter int unsigned NWIRE  = 4,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned NDOM   = 4,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NDOM-1:0]   rst_dom_i,
  input  logic              upd_valid_i,
  input  logic [IDX_W-1:0]  upd_index_i,
  input  logic [NWIRE-1:0]  upd_value_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [NWIRE-1:0]  wire_o,
  output logic [NWIRE-1:0]  irq_status_o,
  output logic              irq_o,
  output logic              wake_o
);
  import hvw_pkg::*;

  localparam int unsigned DOM_W = (NDOM > 1) ? $clog2(NDOM) : 1;

  logic [IDX_W-1:0]      idx_q;
  logic [NWIRE-1:0]      pat_q;
  logic [DOM_W-1:0]      src_q;
  logic [NWIRE-1:0][3:0] sel_q;
  logic                  dom_act, upd_hit;
  logic [NWIRE-1:0]      stat_nxt, hit;
  logic [DATA_W-1:0]     rd_nxt;

  hvw_cfg #(
    .NWIRE(NWIRE), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DOM_W(DOM_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(reg_we_i), .addr(reg_addr_i), .wdata(reg_wdata_i),
    .idx_q(idx_q), .pat_q(pat_q), .src_q(src_q), .sel_q(sel_q)
  );

  assign dom_act = rst_dom_i[src_q];
  assign upd_hit = upd_valid_i && (upd_index_i == idx_q);

  for (genvar g = 0; g < NWIRE; g++) begin : g_wire
    hvw_wire u_wire (
      .clk(clk), .rst(rst),
      .dom_act(dom_act), .dom_val(pat_q[g]),
      .upd_hit(upd_hit), .upd_val(upd_value_i[g]),
      .fw_we(reg_we_i && reg_addr_i == ADDR_W'(OFS_STATE + g)),
      .fw_val(reg_wdata_i[0]),
      .clr(reg_we_i && reg_addr_i == ADDR_W'(OFS_STAT) && reg_wdata_i[g]),
      .sel(sel_q[g]),
      .state_q(wire_o[g]), .stat_q(irq_status_o[g]),
      .stat_nxt(stat_nxt[g]), .hit(hit[g])
    );
  end

  always_comb begin
    rd_nxt = '0;
    if (reg_addr_i == ADDR_W'(OFS_INDEX)) rd_nxt[IDX_W-1:0] = idx_q;
    if (reg_addr_i == ADDR_W'(OFS_RCFG)) begin
      rd_nxt[NWIRE-1:0]             = pat_q;
      rd_nxt[RCFG_DOM_LSB +: DOM_W] = src_q;
    end
    if (reg_addr_i == ADDR_W'(OFS_STAT)) rd_nxt[NWIRE-1:0] = irq_status_o;
    for (int i = 0; i < NWIRE; i++) begin
      if (reg_addr_i == ADDR_W'(OFS_SEL + i))   rd_nxt[3:0] = sel_q[i];
      if (reg_addr_i == ADDR_W'(OFS_STATE + i)) rd_nxt[0]   = wire_o[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata_o <= '0;
      irq_o       <= 1'b0;
      wake_o      <= 1'b0;
    end else begin
      reg_rdata_o <= rd_nxt;
      irq_o       <= |stat_nxt;
      wake_o      <= |hit;
    end
  end

endmodule

// File: rtl/hvw_rx_chk.sv
module hvw_rx_chk #(
  parameter int unsigned NWIRE = 4,
  parameter int unsigned IDX_W = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  upd_valid_i,
  input logic [IDX_W-1:0]      upd_index_i,
  input logic                  reg_we_i,
  input logic [IDX_W-1:0]      idx_q,
  input logic [NWIRE-1:0]      pat_q,
  input logic [NWIRE-1:0][3:0] sel_q,
  input logic                  dom_act,
  input logic [NWIRE-1:0]      wire_o,
  input logic [NWIRE-1:0]      irq_status_o,
  input logic                  irq_o,
  input logic                  wake_o
);

  assert_mismatch_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (upd_valid_i && upd_index_i != idx_q && !dom_act && !reg_we_i) |=> $stable(wire_o));

  assert_domain_pattern_R8: assert property (@(posedge clk) disable iff (rst)
    dom_act |=> (wire_o == $past(pat_q)));

  assert_irq_or_R9: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|irq_status_o));

  assert_wake_needs_change_R10: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> (wire_o != $past(wire_o)));

  for (genvar g = 0; g < NWIRE; g++) begin : g_w
    assert_off_quiet_R6: assert property (@(posedge clk) disable iff (rst)
      (sel_q[g] == 4'h4) |=> !irq_status_o[g]);
    assert_level_high_R4: assert property (@(posedge clk) disable iff (rst)
      (sel_q[g] == 4'h1) |=> (irq_status_o[g] == wire_o[g]));
  end

endmodule

bind hvw_rx hvw_rx_chk #(.NWIRE(NWIRE), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .upd_valid_i(upd_valid_i), .upd_index_i(upd_index_i),
  .reg_we_i(reg_we_i), .idx_q(idx_q), .pat_q(pat_q), .sel_q(sel_q), .dom_act(dom_act),
  .wire_o(wire_o), .irq_status_o(irq_status_o), .irq_o(irq_o), .wake_o(wake_o)
);

// File: tb/tb_hvw_rx.sv
module tb_hvw_rx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] rst_dom_i = '0;
  logic       upd_valid_i = 1'b0;
  logic [7:0] upd_index_i = '0;
  logic [3:0] upd_value_i = '0;
  logic       reg_we_i = 1'b0;
  logic [3:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic [3:0] wire_o, irq_status_o;
  logic       irq_o, wake_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  hvw_rx dut (.*);

  always #4 clk = ~clk;

  // {index, values, clear mask, expected wires, expected status}
  localparam logic [23:0] VEC [8] = '{
    {8'h5A, 4'hF, 4'h0, 4'hF, 4'hE},
    {8'h5A, 4'h0, 4'hC, 4'h0, 4'h1},
    {8'h33, 4'hF, 4'h0, 4'h0, 4'h1},
    {8'h5A, 4'h4, 4'h0, 4'h4, 4'h5},
    {8'h5A, 4'h4, 4'h4, 4'h4, 4'h1},
    {8'h5A, 4'h8, 4'h8, 4'h8, 4'h1},
    {8'h5A, 4'h0, 4'h0, 4'h0, 4'h9},
    {8'h5A, 4'h3, 4'h8, 4'h3, 4'h2}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr_i = a;
    @(negedge clk);
    d = reg_rdata_o;
  endtask

  task automatic upd(input logic [7:0] i, input logic [3:0] v);
    @(negedge clk);
    upd_valid_i = 1'b1; upd_index_i = i; upd_value_i = v;
    @(negedge clk);
    upd_valid_i = 1'b0;
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 wires", wire_o, 4'h0);
    check("R1 status", irq_status_o, 4'h0);
    check("R1 irq", irq_o, 1'b0);
    rd(4'd0, d); check("R1 index byte", d, 8'h00);
    rd(4'd5, d); check("R1 select byte", d, 8'h04);

    wr(4'd0, 8'h5A);
    wr(4'd4, 8'h00);
    wr(4'd5, 8'h01);
    wr(4'd6, 8'h0E);
    wr(4'd7, 8'h0F);
    check("R4 low level at setup", irq_status_o, 4'h1);

    for (int k = 0; k < 8; k++) begin
      upd(VEC[k][23:16], VEC[k][15:12]);
      if (VEC[k][11:8] != 4'h0) wr(4'd2, {4'h0, VEC[k][11:8]});
      check($sformatf("R2 wires vec%0d", k), wire_o, VEC[k][7:4]);
      check($sformatf("R4/R5/R7 status vec%0d", k), irq_status_o, VEC[k][3:0]);
      check($sformatf("R9 irq vec%0d", k), irq_o, |VEC[k][3:0]);
    end

    // R3 byte isolation of select codes
    wr(4'd6, 8'h0D);
    rd(4'd4, d); check("R3 sel0", d, 8'h00);
    rd(4'd5, d); check("R3 sel1", d, 8'h01);
    rd(4'd6, d); check("R3 sel2", d, 8'h0D);
    rd(4'd7, d); check("R3 sel3", d, 8'h0F);

    // R6 undefined code behaves as off
    wr(4'd4, 8'h07);
    upd(8'h5A, 4'h0);
    check("R6 status", irq_status_o, 4'h0);
    upd(8'h5A, 4'h1);
    check("R6 undefined edge status", irq_status_o, 4'h0);
    check("R10 no wake undefined", wake_o, 1'b0);

    // R5 falling-only mode on wire 2
    upd(8'h5A, 4'h5);
    check("R5 rise ignored in fall mode", irq_status_o, 4'h0);
    check("R10 no wake", wake_o, 1'b0);
    upd(8'h5A, 4'h1);
    check("R5 fall sets", irq_status_o, 4'h4);
    check("R10 wake pulse", wake_o, 1'b1);
    @(negedge clk);
    check("R10 wake one cycle", wake_o, 1'b0);
    upd(8'h5A, 4'h5);
    @(negedge clk);
    upd_valid_i = 1'b1; upd_index_i = 8'h5A; upd_value_i = 4'h1;
    reg_we_i = 1'b1; reg_addr_i = 4'd2; reg_wdata_i = 8'h04;
    @(negedge clk);
    upd_valid_i = 1'b0; reg_we_i = 1'b0;
    check("R5 edge beats clear", irq_status_o, 4'h4);
    wr(4'd2, 8'h04);
    check("R5 clear", irq_status_o, 4'h0);

    // R3 firmware state write
    wr(4'd11, 8'h01);
    check("R3 state write", wire_o, 4'h9);
    rd(4'd11, d); check("R3 state3 read", d, 8'h01);
    rd(4'd10, d); check("R3 state2 read", d, 8'h00);

    // R8 reset domain
    wr(4'd1, 8'h2A);
    rd(4'd1, d); check("R3 rcfg read", d, 8'h2A);
    @(negedge clk); rst_dom_i = 4'b0010;
    @(negedge clk); rst_dom_i = 4'b0000;
    check("R8 other domain ignored", wire_o, 4'h9);
    @(negedge clk);
    rst_dom_i = 4'b0100;
    upd_valid_i = 1'b1; upd_index_i = 8'h5A; upd_value_i = 4'h0;
    @(negedge clk);
    upd_valid_i = 1'b0;
    check("R8 pattern over update", wire_o, 4'hA);
    @(negedge clk); rst_dom_i = 4'b0000;
    upd(8'h5A, 4'h5);
    check("R8 released", wire_o, 4'h5);

    // R4 level status not clearable
    upd(8'h5A, 4'h7);
    check("R4 high level", irq_status_o[1], 1'b1);
    wr(4'd2, 8'h02);
    check("R4 clear ignored", irq_status_o[1], 1'b1);

    // R1 reset again
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R1 wires after reset", wire_o, 4'h0);
    check("R1 status after reset", irq_status_o, 4'h0);
    rd(4'd6, d); check("R1 select after reset", d, 8'h04);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule